// File: doc/BRIEF.md
# Stacked DRAM Command Timing Gate

This block sits next to the scheduler of one channel of a stacked DRAM controller and answers one question each cycle: may the proposed command go out now? The scheduler presents a command type together with its stack, rank, bank-group and bank indices. The block replies with a combinational permission flag. When the scheduler actually sends a command, it raises a commit strobe with the same fields on the inputs. On that strobe the block moves the earliest-allowed times forward in its tables. There is one table per bank, per bank group, per rank and per stack, and one register for the shared row-command bus.

A free-running cycle counter is the time base. The earliest time for a command is the largest of the current time and every table entry that applies to its type. The command is allowed once the counter has reached that time. Every table update takes the larger of the stored value and the new limit, so an entry can only move forward in time.

Next to the usual bank, group and rank spacing, the block spaces reads that switch from one stack to another. A read or read-with-autoprecharge to one stack holds off reads on every other stack for a separate gap. Reads to the same stack are left alone by this rule. Each rank also keeps a history of its last four activates, which enforces the four-activate window.

Top module: `stk_dram_timer`

## Requirements
- R1: After reset every table entry and the counter read zero and the activate history of every rank is empty, so any command is allowed in the first cycle after reset, including after a mid-run reset.
- R2: Command encoding: 0 = ACT, 1 = PRE, 2 = RD, 3 = RDA. `bnk` selects a bank inside the bank group `grp`. `ok` is high exactly when the counter is at or past the largest applicable table entry; a commit updates the tables at the next clock edge.
- R3: A committed ACT holds off RD/RDA to the same bank for T_RCD (7), PRE to it for T_RAS (17) and ACT to it for T_RC (24) cycles.
- R4: A committed PRE holds off ACT to the same bank for T_RP (7) cycles.
- R5: A committed RD or RDA holds off PRE to the same bank for T_RTP (3) cycles. An RDA also holds off ACT to that bank for T_RTP + T_RP (10) cycles.
- R6: A read holds off reads to the same bank group for T_CCDL (3) cycles. It holds off reads elsewhere in the same rank for the larger of T_CCDS (2) and the burst time BURST_LEN / DATA_RATE × T_CK (2). Reads to another rank in the same stack are not held by these gaps.
- R7: An ACT holds off ACT to the same bank group for T_RRDL (4) cycles and to the rest of the same rank for T_RRDS (2) cycles.
- R8: A committed RD or RDA to one stack holds off both RD and RDA on every other stack for T_CCDR (2) cycles, even when the rank differs.
- R9: The stack-switch gap does not apply to reads aimed at the same stack as the committed read.
- R10: Any committed ACT or PRE holds off every ACT and PRE in the channel for T_ROWBUS (2) cycles, across banks and ranks.
- R11: A fifth ACT in a rank waits until T_FAW (16) cycles after the oldest of that rank's last four ACTs; other ranks are not affected.
- R12: A commit whose limit is earlier than a stored entry leaves that entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Command type (0 ACT, 1 PRE, 2 RD, 3 RDA) |
| stk | input | SW | Stack index |
| rnk | input | RW | Rank index |
| grp | input | GW | Bank group index |
| bnk | input | BW | Bank index within the group |
| commit | input | 1 | Command is sent this cycle; update the tables |
| ok | output | 1 | Proposed command may issue this cycle |

## Verification
Each timing rule is tested with a committed command followed by a probe one cycle before and exactly at the expected gap, so an off-by-one on any parameter shows up. The probe targets are chosen so that only one rule can be the limiting one. Reads that switch stack are paired with a different rank, so the stack gap cannot hide behind the rank gap. Same-stack reads to another rank show the gap does not apply there. Row commands in another rank isolate the shared row bus. Four quick activates followed by a fifth separate the activate window from the shorter activate gaps. An ACT followed by a PRE to the same bank shows that the shorter limit does not overwrite the longer one.

// File: rtl/stk_dram_timer.sv
module stk_dram_timer #(
  parameter int N_STACK   = 2,
  parameter int N_RANK    = 2,
  parameter int N_BG      = 4,
  parameter int N_BANK    = 16,
  parameter int TW        = 32,
  parameter int T_RCD     = 7,
  parameter int T_RP      = 7,
  parameter int T_RAS     = 17,
  parameter int T_RC      = 24,
  parameter int T_RTP     = 3,
  parameter int T_RRDL    = 4,
  parameter int T_RRDS    = 2,
  parameter int T_FAW     = 16,
  parameter int T_CCDL    = 3,
  parameter int T_CCDS    = 2,
  parameter int T_CCDR    = 2,
  parameter int T_ROWBUS  = 2,
  parameter int BURST_LEN = 4,
  parameter int DATA_RATE = 2,
  parameter int T_CK      = 1,
  localparam int N_BPG    = N_BANK / N_BG,
  localparam int SW       = N_STACK > 1 ? $clog2(N_STACK) : 1,
  localparam int RW       = N_RANK > 1 ? $clog2(N_RANK) : 1,
  localparam int GW       = N_BG > 1 ? $clog2(N_BG) : 1,
  localparam int BW       = N_BPG > 1 ? $clog2(N_BPG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cmd,
  input  logic [SW-1:0] stk,
  input  logic [RW-1:0] rnk,
  input  logic [GW-1:0] grp,
  input  logic [BW-1:0] bnk,
  input  logic          commit,
  output logic          ok
);
  localparam int NB_ALL  = N_STACK * N_RANK * N_BANK;
  localparam int NG_ALL  = N_STACK * N_RANK * N_BG;
  localparam int BI_W    = NB_ALL > 1 ? $clog2(NB_ALL) : 1;
  localparam int GI_W    = NG_ALL > 1 ? $clog2(NG_ALL) : 1;
  localparam int T_BURST = (BURST_LEN / DATA_RATE) * T_CK;
  localparam int T_RDGAP = T_CCDS > T_BURST ? T_CCDS : T_BURST;
  localparam int FAW_N   = 4;
  localparam int FI_W    = $clog2(FAW_N);
  localparam int FC_W    = $clog2(FAW_N + 1);
  localparam logic [1:0] C_ACT = 2'd0, C_PRE = 2'd1, C_RD = 2'd2, C_RDA = 2'd3;

  logic [TW-1:0]   now, row_free, earliest;
  logic [TW-1:0]   bk_act [NB_ALL];
  logic [TW-1:0]   bk_pre [NB_ALL];
  logic [TW-1:0]   bk_rd  [NB_ALL];
  logic [TW-1:0]   grp_act [NG_ALL];
  logic [TW-1:0]   grp_rd  [NG_ALL];
  logic [TW-1:0]   rk_act [N_RANK];
  logic [TW-1:0]   rk_rd  [N_RANK];
  logic [TW-1:0]   st_rd  [N_STACK];
  logic [TW-1:0]   faw_t  [N_RANK][FAW_N];
  logic [FC_W-1:0] faw_n  [N_RANK];
  logic [BI_W-1:0] bi;
  logic [GI_W-1:0] gi;
  logic [TW-1:0]   faw_lim;

  function automatic logic [TW-1:0] mx(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign gi = GI_W'((int'(stk) * N_RANK + int'(rnk)) * N_BG + int'(grp));
  assign bi = BI_W'(((int'(stk) * N_RANK + int'(rnk)) * N_BG + int'(grp)) * N_BPG + int'(bnk));
  assign faw_lim = (faw_n[rnk] == FC_W'(FAW_N)) ? faw_t[rnk][0] + TW'(T_FAW) : '0;

  always_comb begin
    unique case (cmd)
      C_ACT:   earliest = mx(mx(mx(bk_act[bi], grp_act[gi]), mx(rk_act[rnk], faw_lim)), row_free);
      C_PRE:   earliest = mx(bk_pre[bi], row_free);
      default: earliest = mx(mx(bk_rd[bi], grp_rd[gi]), mx(rk_rd[rnk], st_rd[stk]));
    endcase
  end

  assign ok = now >= earliest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now      <= '0;
      row_free <= '0;
      for (int i = 0; i < NB_ALL; i++) begin
        bk_act[i] <= '0;
        bk_pre[i] <= '0;
        bk_rd[i]  <= '0;
      end
      for (int i = 0; i < NG_ALL; i++) begin
        grp_act[i] <= '0;
        grp_rd[i]  <= '0;
      end
      for (int r = 0; r < N_RANK; r++) begin
        rk_act[r] <= '0;
        rk_rd[r]  <= '0;
        faw_n[r]  <= '0;
        for (int k = 0; k < FAW_N; k++) faw_t[r][k] <= '0;
      end
      for (int s = 0; s < N_STACK; s++) st_rd[s] <= '0;
    end else begin
      now <= now + 1'b1;
      if (commit) begin
        unique case (cmd)
          C_ACT: begin
            bk_act[bi]  <= mx(bk_act[bi],  now + TW'(T_RC));
            bk_pre[bi]  <= mx(bk_pre[bi],  now + TW'(T_RAS));
            bk_rd[bi]   <= mx(bk_rd[bi],   now + TW'(T_RCD));
            grp_act[gi] <= mx(grp_act[gi], now + TW'(T_RRDL));
            rk_act[rnk] <= mx(rk_act[rnk], now + TW'(T_RRDS));
            row_free    <= mx(row_free,    now + TW'(T_ROWBUS));
            if (faw_n[rnk] < FC_W'(FAW_N)) begin
              faw_t[rnk][FI_W'(faw_n[rnk])] <= now;
              faw_n[rnk] <= faw_n[rnk] + 1'b1;
            end else begin
              for (int k = 0; k < FAW_N - 1; k++) faw_t[rnk][k] <= faw_t[rnk][k+1];
              faw_t[rnk][FAW_N-1] <= now;
            end
          end
          C_PRE: begin
            bk_act[bi] <= mx(bk_act[bi], now + TW'(T_RP));
            row_free   <= mx(row_free,   now + TW'(T_ROWBUS));
          end
          C_RD, C_RDA: begin
            bk_pre[bi] <= mx(bk_pre[bi], now + TW'(T_RTP));
            if (cmd == C_RDA) bk_act[bi] <= mx(bk_act[bi], now + TW'(T_RTP + T_RP));
            grp_rd[gi]  <= mx(grp_rd[gi],  now + TW'(T_CCDL));
            rk_rd[rnk]  <= mx(rk_rd[rnk],  now + TW'(T_RDGAP));
            for (int s = 0; s < N_STACK; s++)
              if (SW'(s) != stk) st_rd[s] <= mx(st_rd[s], now + TW'(T_CCDR));
          end
        endcase
      end
    end
  end
endmodule

module stk_dram_timer_chk #(
  parameter int SW       = 1,
  parameter int N_STACK  = 2,
  parameter int TW       = 32,
  parameter int T_CCDR   = 2,
  parameter int T_ROWBUS = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cmd,
  input logic [SW-1:0] stk,
  input logic          commit,
  input logic          ok,
  input logic [TW-1:0] now,
  input logic [TW-1:0] row_free,
  input logic [TW-1:0] st_rd [N_STACK]
);
  // R1
  reset_open_chk: assert property (@(posedge clk) disable iff (!rst_n) $past(!rst_n) |-> ok);

  // R12
  row_mono_chk: assert property (@(posedge clk) disable iff (!rst_n) row_free >= $past(row_free));

  // R10
  row_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !cmd[1] |=> row_free >= $past(now) + TW'(T_ROWBUS));

  for (genvar s = 0; s < N_STACK; s++) begin : g_stk
    // R8
    stack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit && cmd[1] && stk != SW'(s) |=> st_rd[s] >= $past(now) + TW'(T_CCDR));
    // R9
    same_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit && cmd[1] && stk == SW'(s) |=> st_rd[s] == $past(st_rd[s]));
  end
endmodule

bind stk_dram_timer stk_dram_timer_chk #(
  .SW(SW), .N_STACK(N_STACK), .TW(TW), .T_CCDR(T_CCDR), .T_ROWBUS(T_ROWBUS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .stk(stk), .commit(commit), .ok(ok),
  .now(now), .row_free(row_free), .st_rd(st_rd)
);

// File: tb/stk_dram_timer_bench.sv
module stk_dram_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] ACT = 2'd0, PRE = 2'd1, RD = 2'd2, RDA = 2'd3;

  logic       clk = 1'b0, rst_n = 1'b0, commit = 1'b0;
  logic [1:0] cmd = ACT;
  logic       stk = 1'b0, rnk = 1'b0;
  logic [1:0] grp = 2'd0, bnk = 2'd0;
  logic       ok;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_dram_timer u_stk_dram_timer (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .stk(stk), .rnk(rnk),
    .grp(grp), .bnk(bnk), .commit(commit), .ok(ok)
  );

  typedef struct packed {
    logic [1:0] ac; logic ast; logic ark; logic [1:0] agr; logic [1:0] abk;
    logic [1:0] bc; logic bst; logic brk; logic [1:0] bgr; logic [1:0] bbk;
    logic [5:0] dly; logic ex; logic [3:0] rq;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{ACT,1'b0,1'b0,2'd0,2'd0, RD, 1'b0,1'b0,2'd0,2'd0, 6'd6,  1'b0, 4'd3},  // R3
    '{ACT,1'b0,1'b0,2'd0,2'd0, RD, 1'b0,1'b0,2'd0,2'd0, 6'd7,  1'b1, 4'd3},  // R3
    '{ACT,1'b0,1'b0,2'd0,2'd0, PRE,1'b0,1'b0,2'd0,2'd0, 6'd16, 1'b0, 4'd3},  // R3
    '{ACT,1'b0,1'b0,2'd0,2'd0, PRE,1'b0,1'b0,2'd0,2'd0, 6'd17, 1'b1, 4'd3},  // R3
    '{ACT,1'b0,1'b0,2'd0,2'd0, ACT,1'b0,1'b0,2'd0,2'd0, 6'd23, 1'b0, 4'd3},  // R3
    '{ACT,1'b0,1'b0,2'd0,2'd0, ACT,1'b0,1'b0,2'd0,2'd0, 6'd24, 1'b1, 4'd3},  // R3
    '{PRE,1'b0,1'b0,2'd1,2'd2, ACT,1'b0,1'b0,2'd1,2'd2, 6'd6,  1'b0, 4'd4},  // R4
    '{PRE,1'b0,1'b0,2'd1,2'd2, ACT,1'b0,1'b0,2'd1,2'd2, 6'd7,  1'b1, 4'd4},  // R4
    '{RD, 1'b0,1'b0,2'd0,2'd0, PRE,1'b0,1'b0,2'd0,2'd0, 6'd2,  1'b0, 4'd5},  // R5
    '{RD, 1'b0,1'b0,2'd0,2'd0, PRE,1'b0,1'b0,2'd0,2'd0, 6'd3,  1'b1, 4'd5},  // R5
    '{RDA,1'b1,1'b1,2'd2,2'd1, ACT,1'b1,1'b1,2'd2,2'd1, 6'd9,  1'b0, 4'd5},  // R5
    '{RDA,1'b1,1'b1,2'd2,2'd1, ACT,1'b1,1'b1,2'd2,2'd1, 6'd10, 1'b1, 4'd5},  // R5
    '{RD, 1'b0,1'b0,2'd0,2'd0, RD, 1'b0,1'b0,2'd0,2'd1, 6'd2,  1'b0, 4'd6},  // R6
    '{RD, 1'b0,1'b0,2'd0,2'd0, RD, 1'b0,1'b0,2'd0,2'd1, 6'd3,  1'b1, 4'd6},  // R6
    '{RD, 1'b0,1'b0,2'd0,2'd0, RD, 1'b0,1'b0,2'd1,2'd0, 6'd1,  1'b0, 4'd6},  // R6
    '{RD, 1'b0,1'b0,2'd0,2'd0, RD, 1'b0,1'b0,2'd1,2'd0, 6'd2,  1'b1, 4'd6},  // R6
    '{RD, 1'b0,1'b0,2'd0,2'd0, RD, 1'b0,1'b1,2'd0,2'd0, 6'd1,  1'b1, 4'd6},  // R6
    '{RD, 1'b0,1'b0,2'd0,2'd0, RD, 1'b1,1'b1,2'd0,2'd0, 6'd1,  1'b0, 4'd8},  // R8
    '{RD, 1'b0,1'b0,2'd0,2'd0, RD, 1'b1,1'b1,2'd0,2'd0, 6'd2,  1'b1, 4'd8},  // R8
    '{RDA,1'b0,1'b0,2'd0,2'd0, RDA,1'b1,1'b1,2'd3,2'd3, 6'd1,  1'b0, 4'd8},  // R8
    '{RD, 1'b1,1'b0,2'd0,2'd0, RDA,1'b0,1'b1,2'd0,2'd0, 6'd1,  1'b0, 4'd8},  // R8
    '{RDA,1'b0,1'b0,2'd3,2'd0, RD, 1'b0,1'b1,2'd3,2'd0, 6'd1,  1'b1, 4'd9},  // R9
    '{RD, 1'b1,1'b0,2'd0,2'd0, RD, 1'b1,1'b1,2'd2,2'd0, 6'd1,  1'b1, 4'd9},  // R9
    '{ACT,1'b0,1'b0,2'd0,2'd0, ACT,1'b0,1'b0,2'd1,2'd0, 6'd1,  1'b0, 4'd7},  // R7
    '{ACT,1'b0,1'b0,2'd0,2'd0, ACT,1'b0,1'b0,2'd1,2'd0, 6'd2,  1'b1, 4'd7},  // R7
    '{ACT,1'b0,1'b0,2'd0,2'd0, ACT,1'b0,1'b0,2'd0,2'd1, 6'd3,  1'b0, 4'd7},  // R7
    '{ACT,1'b0,1'b0,2'd0,2'd0, ACT,1'b0,1'b0,2'd0,2'd1, 6'd4,  1'b1, 4'd7},  // R7
    '{ACT,1'b0,1'b0,2'd0,2'd0, PRE,1'b0,1'b1,2'd1,2'd1, 6'd1,  1'b0, 4'd10}, // R10
    '{ACT,1'b0,1'b0,2'd0,2'd0, PRE,1'b0,1'b1,2'd1,2'd1, 6'd2,  1'b1, 4'd10}, // R10
    '{PRE,1'b0,1'b0,2'd0,2'd0, ACT,1'b0,1'b1,2'd2,2'd3, 6'd1,  1'b0, 4'd10}, // R10
    '{PRE,1'b0,1'b0,2'd0,2'd0, ACT,1'b0,1'b1,2'd2,2'd3, 6'd2,  1'b1, 4'd10}  // R10
  };

  task automatic drive(input logic [1:0] c, input logic s, input logic r,
                       input logic [1:0] g, input logic [1:0] b);
    cmd = c; stk = s; rnk = r; grp = g; bnk = b;
  endtask

  task automatic skip(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send(input logic [1:0] c, input logic s, input logic r,
                      input logic [1:0] g, input logic [1:0] b);
    drive(c, s, r, g, b);
    commit = 1'b1;
    @(posedge clk); #1;
    commit = 1'b0;
  endtask

  task automatic probe(input logic [1:0] c, input logic s, input logic r,
                       input logic [1:0] g, input logic [1:0] b,
                       input logic ex, input string tag);
    drive(c, s, r, g, b);
    commit = 1'b0;
    #2;
    checks++;
    if (ok !== ex) begin
      fails++;
      $display("FAIL %s: ok=%0b expected %0b at %0t", tag, ok, ex, $time);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: fresh tables allow every command type
    probe(ACT, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, "R1 ACT after reset");
    probe(PRE, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, "R1 PRE after reset");
    probe(RD,  1'b1, 1'b1, 2'd3, 2'd3, 1'b1, "R1 RD after reset");
    probe(RDA, 1'b0, 1'b1, 2'd2, 2'd1, 1'b1, "R1 RDA after reset");

    // R2 framing: each vector is one commit followed by one probe at a fixed distance
    for (int i = 0; i < NV; i++) begin
      skip(40);
      send(VECS[i].ac, VECS[i].ast, VECS[i].ark, VECS[i].agr, VECS[i].abk);
      skip(int'(VECS[i].dly) - 1);
      probe(VECS[i].bc, VECS[i].bst, VECS[i].brk, VECS[i].bgr, VECS[i].bbk, VECS[i].ex,
            $sformatf("R%0d vector %0d (R2 timing)", VECS[i].rq, i));
    end

    // R11: four activates at 0,2,4,6 then a fifth in the same rank
    skip(40);
    send(ACT, 1'b0, 1'b0, 2'd0, 2'd0); skip(1);
    send(ACT, 1'b0, 1'b0, 2'd1, 2'd0); skip(1);
    send(ACT, 1'b0, 1'b0, 2'd2, 2'd0); skip(1);
    send(ACT, 1'b0, 1'b0, 2'd3, 2'd0); skip(1);
    probe(ACT, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1, "R11 other rank at +8");
    probe(ACT, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, "R11 fifth ACT at +9");
    skip(5);
    probe(ACT, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, "R11 fifth ACT at +15");
    probe(ACT, 1'b0, 1'b0, 2'd0, 2'd1, 1'b1, "R11 fifth ACT at +16");

    // R12: PRE right after ACT must not pull the row-cycle limit back
    skip(40);
    send(ACT, 1'b1, 1'b0, 2'd1, 2'd1);
    send(PRE, 1'b1, 1'b0, 2'd1, 2'd1);
    skip(7);
    probe(ACT, 1'b1, 1'b0, 2'd1, 2'd1, 1'b0, "R12 ACT at +9");
    skip(13);
    probe(ACT, 1'b1, 1'b0, 2'd1, 2'd1, 1'b0, "R12 ACT at +23");
    probe(ACT, 1'b1, 1'b0, 2'd1, 2'd1, 1'b1, "R12 ACT at +24");

    // R1: reset in the middle of activity clears tables and history
    skip(40);
    send(ACT, 1'b0, 1'b0, 2'd0, 2'd0);
    send(ACT, 1'b0, 1'b0, 2'd1, 2'd0);
    send(ACT, 1'b0, 1'b0, 2'd2, 2'd0);
    rst_n = 1'b0;
    skip(2);
    rst_n = 1'b1;
    probe(ACT, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, "R1 ACT after mid-run reset");
    probe(RD,  1'b0, 1'b0, 2'd0, 2'd0, 1'b1, "R1 RD after mid-run reset");
    probe(ACT, 1'b0, 1'b0, 2'd3, 2'd3, 1'b1, "R1 ACT other group after mid-run reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule